// File: doc/BRIEF.md
# Cable Port Power Control

This block decides, cycle by cycle, how much of each twisted-pair cable port in a serial bus physical layer is switched on. For every port it keeps a small state machine with four states: the link layer has switched the port off, no cable is present, the port is in normal use, or the port is suspended. It drives four enables from that state. The transceiver and the bias driver have separate enables because different conditions switch them off. The other two are power gates: one covers the main port circuits, and the other covers the reference and incoming-bias detection circuits, which stay alive while the port is suspended.

A chip-wide power-down input overrides all of this. It returns every port to the no-cable state and drops every enable except detection. It makes the cable-not-active flag look at the raw bias detectors of all ports. It also raises an internal reset request that is held for a fixed number of cycles after power-down is released. The cable-not-active flag is purely combinational and is not debounced, so power-management logic can react to it at once. Suspend and resume arrive only as per-port request levels; the handshake on the cable is handled elsewhere.

Top module: `cable_port_pwr_ctrl`

## Requirements
- R1: While the asynchronous active-low reset is low, every port reads state code 1 (no cable), the transceiver, bias-driver and core-power enables are 0, the detection enable is 1 and the reset request is 0. The state codes are: 0 = link-disabled, 1 = no cable, 2 = active, 3 = suspended.
- R2: A port in state 1 moves to state 2 at the first clock on which its cable-connect input is high. A port in state 2 returns to state 1 when cable-connect is low. Ports change state independently of one another.
- R3: One clock after the cause, the transceiver enable is 1 only when all of these hold: the port's next state is 2, cable-connect is high, the arbitration disable is low and power-down is low.
- R4: The bias-driver enable is 1 only in states 1 and 2 with power-down low. It goes to 0 when the link disables the port or when the port is suspended.
- R5: A high port-off command, with power-down low, puts the port in state 0 and clears its detection enable. When the command is released, the port goes to state 1 first, even if a cable is present.
- R6: A suspend request in state 2 moves the port to state 3. In state 3 the transceiver, bias-driver and core-power enables are 0 and the detection enable is 1. A suspend request in state 3 has no effect.
- R7: In state 3, a resume request or incoming bias takes the port to state 2 if the cable is connected, and to state 1 otherwise. Loss of the cable in state 3 also leads to state 1.
- R8: The cable-not-active output is combinational. It is high when no port in state 2 has its bias-detect input high. Ports in state 1 or 3 with bias present leave it high.
- R9: While power-down is high, cable-not-active is high exactly when no port's bias-detect input is high, whatever the port states. On the next clock every port is in state 1 with only the detection enable on.
- R10: The reset request rises one clock after power-down is sampled high. It stays high for RST_HOLD clocks after power-down is first sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_i | input | 1 | Power-down request |
| cable_conn_i | input | NUM_PORTS | Cable connected, per port |
| bias_det_i | input | NUM_PORTS | Incoming bias detected, per port |
| susp_req_i | input | NUM_PORTS | Suspend request, per port |
| resume_req_i | input | NUM_PORTS | Resume request, per port |
| arb_dis_i | input | NUM_PORTS | Arbitration asks for transceiver off, per port |
| port_off_i | input | NUM_PORTS | Link-layer port disable command, per port |
| xcvr_en_o | output | NUM_PORTS | Transmitter/receiver enable |
| bias_drv_en_o | output | NUM_PORTS | Bias output driver enable |
| core_pwr_en_o | output | NUM_PORTS | Power gate for the main port circuits |
| det_pwr_en_o | output | NUM_PORTS | Power gate for reference and bias detection |
| cna_o | output | 1 | Cable not active |
| rst_req_o | output | 1 | Internal logic reset request |
| port_state_o | output | 2*NUM_PORTS | Per-port state code, port 0 in bits 1:0 |

## Verification
The bench builds the block with NUM_PORTS = 2 and RST_HOLD = 3. Two ports make it possible to test whether cable-not-active counts bias only on active ports: one port sits in the no-cable state with bias present while the other is active. They also show that ports move independently. A short hold of three cycles lets the bench observe the whole reset-request stretch, both its rising and falling edges, inside the vector walk.

// File: rtl/port_pwr_pkg.sv
package port_pwr_pkg;

    typedef enum logic [1:0] {
        PS_DISABLED = 2'd0,
        PS_DISCONN  = 2'd1,
        PS_ACTIVE   = 2'd2,
        PS_SUSPEND  = 2'd3
    } port_state_e;

    typedef struct packed {
        port_state_e st;
        logic        xcvr_en;
        logic        bias_en;
        logic        core_pwr;
        logic        det_pwr;
    } slice_regs_t;

    localparam slice_regs_t SLICE_RESET = '{
        st:       PS_DISCONN,
        xcvr_en:  1'b0,
        bias_en:  1'b0,
        core_pwr: 1'b0,
        det_pwr:  1'b1
    };

endpackage

// File: rtl/port_next_state.sv
module port_next_state
    import port_pwr_pkg::*;
(
    input  port_state_e st_q,
    input  logic        pd,
    input  logic        port_off,
    input  logic        conn,
    input  logic        bias,
    input  logic        susp_req,
    input  logic        resume_req,
    output port_state_e st_d
);

    always_comb begin
        st_d = st_q;
        if (pd) begin
            st_d = PS_DISCONN;
        end else if (port_off) begin
            st_d = PS_DISABLED;
        end else begin
            unique case (st_q)
                PS_DISABLED: st_d = PS_DISCONN;
                PS_DISCONN: begin
                    if (conn) st_d = PS_ACTIVE;
                end
                PS_ACTIVE: begin
                    if (!conn)         st_d = PS_DISCONN;
                    else if (susp_req) st_d = PS_SUSPEND;
                end
                PS_SUSPEND: begin
                    if (resume_req || bias) st_d = conn ? PS_ACTIVE : PS_DISCONN;
                    else if (!conn)         st_d = PS_DISCONN;
                end
                default: st_d = PS_DISCONN;
            endcase
        end
    end

endmodule

// File: rtl/port_pwr_slice.sv
module port_pwr_slice
    import port_pwr_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        pd_i,
    input  logic        port_off_i,
    input  logic        conn_i,
    input  logic        bias_i,
    input  logic        susp_req_i,
    input  logic        resume_req_i,
    input  logic        arb_dis_i,
    output port_state_e st_o,
    output logic        xcvr_en_o,
    output logic        bias_en_o,
    output logic        core_pwr_o,
    output logic        det_pwr_o
);

    slice_regs_t r_d, r_q;
    port_state_e st_next;

    port_next_state u_next (
        .st_q       (r_q.st),
        .pd         (pd_i),
        .port_off   (port_off_i),
        .conn       (conn_i),
        .bias       (bias_i),
        .susp_req   (susp_req_i),
        .resume_req (resume_req_i),
        .st_d       (st_next)
    );

    always_comb begin
        r_d          = r_q;
        r_d.st       = st_next;
        r_d.xcvr_en  = !pd_i && conn_i && !arb_dis_i && (st_next == PS_ACTIVE);
        r_d.bias_en  = !pd_i && ((st_next == PS_ACTIVE) || (st_next == PS_DISCONN));
        r_d.core_pwr = !pd_i && (st_next != PS_SUSPEND);
        r_d.det_pwr  = pd_i || (st_next != PS_DISABLED);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= SLICE_RESET;
        else         r_q <= r_d;
    end

    assign st_o       = r_q.st;
    assign xcvr_en_o  = r_q.xcvr_en;
    assign bias_en_o  = r_q.bias_en;
    assign core_pwr_o = r_q.core_pwr;
    assign det_pwr_o  = r_q.det_pwr;

    // R3
    xcvr_only_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.xcvr_en |-> (r_q.st == PS_ACTIVE));

    // R4
    bias_off_when_parked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.bias_en |-> (r_q.st == PS_ACTIVE || r_q.st == PS_DISCONN));

    // R6
    suspend_gating_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == PS_SUSPEND) |-> (!r_q.core_pwr && r_q.det_pwr && !r_q.xcvr_en));

    // R5
    port_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (port_off_i && !pd_i) |=> (r_q.st == PS_DISABLED && !r_q.det_pwr));

    // R9
    pd_forces_disconn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pd_i |=> (r_q.st == PS_DISCONN && r_q.det_pwr && !r_q.core_pwr));

    // R7
    resume_no_cable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == PS_SUSPEND && !conn_i && !pd_i && !port_off_i) |=> (r_q.st == PS_DISCONN));

endmodule

// File: rtl/cna_detect.sv
module cna_detect
    import port_pwr_pkg::*;
#(
    parameter int NUM_PORTS = 1
) (
    input  logic                 pd_i,
    input  logic [NUM_PORTS-1:0] bias_det_i,
    input  logic [NUM_PORTS-1:0] port_active_i,
    output logic                 cna_o
);

    logic [NUM_PORTS-1:0] live;

    always_comb begin
        live  = pd_i ? bias_det_i : (bias_det_i & port_active_i);
        cna_o = ~|live;
    end

    // R8
    always_comb begin
        if (!pd_i && (port_active_i == '0))
            cna_idle_chk: assert (cna_o);
    end

endmodule

// File: rtl/reset_stretch.sv
module reset_stretch #(
    parameter int RST_HOLD = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pd_i,
    output logic rst_req_o
);

    localparam int CNT_W = $clog2(RST_HOLD + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
    } stretch_regs_t;

    stretch_regs_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.req = pd_i || (s_q.cnt != '0);
        if (pd_i)               s_d.cnt = CNT_W'(RST_HOLD);
        else if (s_q.cnt != '0) s_d.cnt = s_q.cnt - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign rst_req_o = s_q.req;

    // R10
    pd_raises_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pd_i |=> rst_req_o);

    // R10
    no_req_without_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pd_i && s_q.cnt == '0) |=> !rst_req_o);

endmodule

// File: rtl/cable_port_pwr_ctrl.sv
module cable_port_pwr_ctrl
    import port_pwr_pkg::*;
#(
    parameter int NUM_PORTS = 1,
    parameter int RST_HOLD  = 16
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   pd_i,
    input  logic [NUM_PORTS-1:0]   cable_conn_i,
    input  logic [NUM_PORTS-1:0]   bias_det_i,
    input  logic [NUM_PORTS-1:0]   susp_req_i,
    input  logic [NUM_PORTS-1:0]   resume_req_i,
    input  logic [NUM_PORTS-1:0]   arb_dis_i,
    input  logic [NUM_PORTS-1:0]   port_off_i,
    output logic [NUM_PORTS-1:0]   xcvr_en_o,
    output logic [NUM_PORTS-1:0]   bias_drv_en_o,
    output logic [NUM_PORTS-1:0]   core_pwr_en_o,
    output logic [NUM_PORTS-1:0]   det_pwr_en_o,
    output logic                   cna_o,
    output logic                   rst_req_o,
    output logic [2*NUM_PORTS-1:0] port_state_o
);

    logic [NUM_PORTS-1:0] port_active;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        port_state_e st;

        port_pwr_slice u_slice (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .pd_i         (pd_i),
            .port_off_i   (port_off_i[p]),
            .conn_i       (cable_conn_i[p]),
            .bias_i       (bias_det_i[p]),
            .susp_req_i   (susp_req_i[p]),
            .resume_req_i (resume_req_i[p]),
            .arb_dis_i    (arb_dis_i[p]),
            .st_o         (st),
            .xcvr_en_o    (xcvr_en_o[p]),
            .bias_en_o    (bias_drv_en_o[p]),
            .core_pwr_o   (core_pwr_en_o[p]),
            .det_pwr_o    (det_pwr_en_o[p])
        );

        assign port_active[p]          = (st == PS_ACTIVE);
        assign port_state_o[2*p +: 2]  = st;
    end

    cna_detect #(.NUM_PORTS(NUM_PORTS)) u_cna (
        .pd_i          (pd_i),
        .bias_det_i    (bias_det_i),
        .port_active_i (port_active),
        .cna_o         (cna_o)
    );

    reset_stretch #(.RST_HOLD(RST_HOLD)) u_rst (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pd_i      (pd_i),
        .rst_req_o (rst_req_o)
    );

endmodule

// File: tb/tb_cable_port_pwr_ctrl.sv
module tb_cable_port_pwr_ctrl;

    localparam int NP   = 2;
    localparam int HOLD = 3;
    localparam int NVEC = 18;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic          pd = 1'b0;
    logic [NP-1:0] conn = '0, bias = '0, susp = '0, res = '0, arb = '0, off = '0;
    logic [NP-1:0] xcvr, biasen, core, det;
    logic          cna, rstreq;
    logic [2*NP-1:0] st;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cable_port_pwr_ctrl #(.NUM_PORTS(NP), .RST_HOLD(HOLD)) dut (
        .clk_i(clk), .rst_ni(rst_ni), .pd_i(pd),
        .cable_conn_i(conn), .bias_det_i(bias), .susp_req_i(susp),
        .resume_req_i(res), .arb_dis_i(arb), .port_off_i(off),
        .xcvr_en_o(xcvr), .bias_drv_en_o(biasen), .core_pwr_en_o(core),
        .det_pwr_en_o(det), .cna_o(cna), .rst_req_o(rstreq), .port_state_o(st)
    );

    // inputs {pd,off,conn,bias,susp,res,arb} _ state _ {xcvr,bias,core,det} _ rst_req (port 0)
    localparam logic [13:0] VEC [NVEC] = '{
        14'b0010000_10_1111_0,
        14'b0010001_10_0111_0,
        14'b0010100_11_0001_0,
        14'b0010000_11_0001_0,
        14'b0011000_10_1111_0,
        14'b0010100_11_0001_0,
        14'b0000010_01_0111_0,
        14'b0000000_01_0111_0,
        14'b0110000_00_0010_0,
        14'b0010000_01_0111_0,
        14'b0010000_10_1111_0,
        14'b0000000_01_0111_0,
        14'b0010000_10_1111_0,
        14'b1010000_01_0001_1,
        14'b0010000_10_1111_1,
        14'b0010100_11_0001_1,
        14'b0010110_10_1111_1,
        14'b0010000_10_1111_0
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 10, 11, 12, 14: return "R2";
            1:                 return "R3";
            2, 3, 5:           return "R6";
            15:                return "R6";
            4, 6, 16:          return "R7";
            7:                 return "R2";
            8, 9:              return "R5";
            13:                return "R9";
            default:           return "R10";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (2) @(negedge clk);
        #1;
        // R1 reset state
        check("R1", {st, xcvr, biasen, core, det, rstreq},
              {4'b0101, 2'b00, 2'b00, 2'b00, 2'b11, 1'b0});
        check("R1", {31'b0, cna}, 32'd1);
        @(negedge clk);
        rst_ni = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {pd, off[0], conn[0], bias[0], susp[0], res[0], arb[0]} = VEC[i][13:7];
            @(posedge clk);
            #1;
            check(vec_tag(i), {st[1:0], xcvr[0], biasen[0], core[0], det[0]},
                  {VEC[i][6:5], VEC[i][4:1]});
            check("R10", {31'b0, rstreq}, {31'b0, VEC[i][0]});
        end

        // port 0 now active with cable; port 1 idle without cable
        @(negedge clk);
        {susp[0], res[0], arb[0]} = '0;
        bias[0] = 1'b1;
        #1 check("R8", {31'b0, cna}, 32'd0);
        bias[0] = 1'b0;
        #1 check("R8", {31'b0, cna}, 32'd1);
        bias[1] = 1'b1;
        #1 check("R8", {31'b0, cna}, 32'd1);
        pd = 1'b1;
        #1 check("R9", {31'b0, cna}, 32'd0);
        @(posedge clk);
        #1 check("R9", {st, xcvr, det}, {4'b0101, 2'b00, 2'b11});
        @(negedge clk);
        pd = 1'b0;
        bias[1] = 1'b0;
        conn = 2'b10;
        @(posedge clk);
        #1 check("R2", {28'b0, st}, {28'b0, 4'b1001});
        check("R3", {30'b0, xcvr}, {30'b0, 2'b10});
        @(negedge clk);
        #2 rst_ni = 1'b0;
        #1 check("R1", {st, xcvr, biasen, det}, {4'b0101, 2'b00, 2'b00, 2'b11});
        @(negedge clk);
        rst_ni = 1'b1;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule